// File: doc/BRIEF.md
# Flattened Nested-Loop Multiply-Accumulator

This block sums `A[i] * j` over a two-level index space: an outer index `i` that selects an element of a small signed array, and an inner index `j` that scales it. With the default parameters both indices run from 0 to 19, which gives 400 product terms per call. The two loops are not built as nested hardware. A single counter walks all 400 steps, and the two indices come from it. One memory read and one multiply are issued on every clock, so a call costs the 400 steps plus a short pipeline tail.

The array sits outside the block in a synchronous single-port memory with one cycle of read latency. The block drives the read address and a read enable, and it takes the returned word back one cycle later. A one-cycle `start_i` pulse begins a call. `done_o` pulses once the last product has entered the sum, and `result_o` shows the running total. The total is kept from one call to the next, so each call adds to what the previous calls left. Only the synchronous reset brings the total back to zero.

Top module: `sweep_mac`

## Requirements
- R1: After reset, `rd_en_o` and `done_o` are low and `result_o` is zero.
- R2: A call adds `A[i]*j` to the total for every pair with i in 0..19 and j in 0..19. Array words are 12-bit two's complement, and `result_o` is the 24-bit two's complement total.
- R3: `rd_en_o` is high for exactly 400 consecutive cycles. These begin in the cycle after the clock edge that accepted `start_i`. `rd_addr_o` shows `i`, which holds for 20 consecutive cycles (j = 0..19) and then steps by one, starting at 0.
- R4: The word sampled on `rd_data_i` one cycle after a read is issued is the one used for that read's `i`. It is multiplied by the `j` that was issued along with that address.
- R5: The total is not cleared at `start_i`. After two calls the result is the sum of both calls' contributions.
- R6: `done_o` is high for exactly one cycle: the cycle that follows the 402nd clock edge after the accepting edge. `result_o` then holds the completed total and does not change during the cycle after `done_o`.
- R7: `start_i` has no effect while a call is in progress. It is accepted when the block is idle, and this includes the cycle in which `done_o` is high.
- R8: The total wraps modulo 2^24 when repeated calls exceed the 24-bit signed range.
- R9: A synchronous reset during a call ends it at once. No further reads are issued, no `done_o` pulse appears, and the total becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a call when idle |
| done_o | output | 1 | One-cycle pulse after the final accumulate |
| rd_en_o | output | 1 | Array read request |
| rd_addr_o | output | 5 | Array element index (outer index i) |
| rd_data_i | input | 12 | Signed array word, valid one cycle after the read |
| result_o | output | 24 | Running two's complement total |

## Verification
The assertions rely on the memory returning data exactly one cycle after each read. They also rely on the array staying unchanged while a call is running, because the block has no way to detect data that changes under it. The bench models the memory with that fixed latency and writes new array contents only between calls. It pulses `start_i` during a run to show the pulse is ignored, and it raises reset in the middle of a call, at a point where the pipeline is full.

// File: rtl/sweep_mac_pkg.sv
package sweep_mac_pkg;

  localparam int unsigned DEF_OUTER  = 20;
  localparam int unsigned DEF_INNER  = 20;
  localparam int unsigned DEF_DATA_W = 12;
  localparam int unsigned DEF_ACC_W  = 24;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_FLUSH = 2'd2
  } seq_state_t;

  // Signed array word scaled by the unsigned inner index.
  function automatic logic signed [63:0] scale_by_index(
    input logic signed [31:0] word,
    input logic        [31:0] idx
  );
    logic signed [63:0] idx_w;
    idx_w = $signed({32'd0, idx});
    return 64'(word) * idx_w;
  endfunction

  // Two's complement addition; the caller truncates to its own width.
  function automatic logic [63:0] wrap_sum(
    input logic [63:0] a,
    input logic [63:0] b
  );
    return a + b;
  endfunction

endpackage

// File: rtl/sweep_mac_seq.sv
module sweep_mac_seq #(
  parameter int unsigned OUTER = sweep_mac_pkg::DEF_OUTER,
  parameter int unsigned INNER = sweep_mac_pkg::DEF_INNER,
  localparam int unsigned TOTAL = OUTER * INNER,
  localparam int unsigned CW = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int unsigned IW = (OUTER > 1) ? $clog2(OUTER) : 1,
  localparam int unsigned JW = (INNER > 1) ? $clog2(INNER) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          drain_done,
  output logic          issue,
  output logic          issue_last,
  output logic [IW-1:0] i_idx,
  output logic [JW-1:0] j_idx
);
  import sweep_mac_pkg::*;

  seq_state_t    state;
  logic [CW-1:0] flat_cnt;
  logic          j_wrap;

  assign issue      = (state == SEQ_RUN);
  assign issue_last = issue && (flat_cnt == CW'(TOTAL - 1));
  assign j_wrap     = (j_idx == JW'(INNER - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      flat_cnt <= '0;
      i_idx    <= '0;
      j_idx    <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          flat_cnt <= '0;
          i_idx    <= '0;
          j_idx    <= '0;
          if (start) state <= SEQ_RUN;
        end
        SEQ_RUN: begin
          if (issue_last) begin
            state    <= SEQ_FLUSH;
            flat_cnt <= '0;
            i_idx    <= '0;
            j_idx    <= '0;
          end else begin
            flat_cnt <= flat_cnt + 1'b1;
            if (j_wrap) begin
              j_idx <= '0;
              i_idx <= i_idx + 1'b1;
            end else begin
              j_idx <= j_idx + 1'b1;
            end
          end
        end
        SEQ_FLUSH: begin
          if (drain_done) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && j_idx != '0) |-> (i_idx == $past(i_idx)));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !issue_last) |=> (issue && flat_cnt == CW'($past(flat_cnt) + 1'b1)));

endmodule

// File: rtl/sweep_mac_dp.sv
module sweep_mac_dp #(
  parameter int unsigned INNER  = sweep_mac_pkg::DEF_INNER,
  parameter int unsigned DATA_W = sweep_mac_pkg::DEF_DATA_W,
  parameter int unsigned ACC_W  = sweep_mac_pkg::DEF_ACC_W,
  localparam int unsigned JW = (INNER > 1) ? $clog2(INNER) : 1,
  localparam longint PROD_MAX = (64'sd1 <<< (DATA_W - 1)) * longint'(INNER - 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     issue,
  input  logic                     issue_last,
  input  logic [JW-1:0]            j_idx,
  input  logic signed [DATA_W-1:0] rd_data,
  output logic                     last_acc,
  output logic                     done,
  output logic [ACC_W-1:0]         acc
);
  import sweep_mac_pkg::*;

  // Stage 1: index and flags wait for the memory word.
  logic          s1_vld, s1_last;
  logic [JW-1:0] s1_j;
  // Stage 2: registered product.
  logic                    s2_vld, s2_last;
  logic signed [ACC_W-1:0] s2_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      s1_j    <= '0;
    end else begin
      s1_vld  <= issue;
      s1_last <= issue_last;
      s1_j    <= j_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_last <= 1'b0;
      s2_prod <= '0;
    end else begin
      s2_vld  <= s1_vld;
      s2_last <= s1_vld && s1_last;
      if (s1_vld) s2_prod <= ACC_W'(scale_by_index(32'(rd_data), 32'(s1_j)));
    end
  end

  assign last_acc = s2_vld && s2_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      done <= 1'b0;
    end else begin
      if (s2_vld) acc <= ACC_W'(wrap_sum(64'(acc), 64'(s2_prod)));
      done <= last_acc;
    end
  end

  // R2
  prod_range_chk: assert property (@(posedge clk) disable iff (rst)
    s2_vld |-> (longint'(s2_prod) <= PROD_MAX && longint'(s2_prod) >= -PROD_MAX));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/sweep_mac.sv
module sweep_mac #(
  parameter int unsigned OUTER  = sweep_mac_pkg::DEF_OUTER,
  parameter int unsigned INNER  = sweep_mac_pkg::DEF_INNER,
  parameter int unsigned DATA_W = sweep_mac_pkg::DEF_DATA_W,
  parameter int unsigned ACC_W  = sweep_mac_pkg::DEF_ACC_W,
  localparam int unsigned IW = (OUTER > 1) ? $clog2(OUTER) : 1,
  localparam int unsigned JW = (INNER > 1) ? $clog2(INNER) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [IW-1:0]     rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ACC_W-1:0]  result_o
);

  logic          issue, issue_last, last_acc;
  logic [JW-1:0] j_idx;

  sweep_mac_seq #(.OUTER(OUTER), .INNER(INNER)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .drain_done (last_acc),
    .issue      (issue),
    .issue_last (issue_last),
    .i_idx      (rd_addr_o),
    .j_idx      (j_idx)
  );

  sweep_mac_dp #(.INNER(INNER), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_last (issue_last),
    .j_idx      (j_idx),
    .rd_data    ($signed(rd_data_i)),
    .last_acc   (last_acc),
    .done       (done_o),
    .acc        (result_o)
  );

  assign rd_en_o = issue;

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> $stable(result_o));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !rd_en_o);

endmodule

// File: tb/sweep_mac_bench.sv
module sweep_mac_bench;

  localparam int NO = 20;
  localparam int NI = 20;
  localparam int DONE_PH = NO * NI + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        done_o, rd_en_o;
  logic [4:0]  rd_addr_o;
  logic [11:0] rd_data_i = '0;
  logic [23:0] result_o;

  logic signed [11:0] mem [0:NO-1];

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  int cyc = 0;

  // behavioural reference state
  int          m_phase = -1;
  logic [23:0] m_acc = '0;
  logic [23:0] tot = '0;

  always #2.5 clk = ~clk;

  sweep_mac u_sweep_mac (
    .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .result_o(result_o)
  );

  always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model advances on each edge
  always @(posedge clk) begin
    int n;
    if (rst) begin
      m_phase = -1;
      m_acc   = '0;
    end else begin
      if ((m_phase == -1 || m_phase == DONE_PH) && start_i) n = 0;
      else if (m_phase == DONE_PH || m_phase < 0) n = -1;
      else n = m_phase + 1;
      if (n >= 3 && n <= DONE_PH)
        m_acc = m_acc + 24'(int'(mem[(n - 3) / NI]) * ((n - 3) % NI));
      m_phase = n;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    bit e_en;
    if (chk_on) begin
      e_en = (m_phase >= 0 && m_phase < NO * NI);
      chk(rd_en_o == e_en, "R3 rd_en", rd_en_o, e_en);
      if (e_en) chk(rd_addr_o == 5'(m_phase / NI), "R3 rd_addr", rd_addr_o, m_phase / NI);
      chk(done_o == (m_phase == DONE_PH), "R6 done", done_o, m_phase == DONE_PH);
      chk(result_o == m_acc, "R2 R4 result", result_o, m_acc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [23:0] call_sum();
    int s = 0;
    for (int i = 0; i < NO; i++)
      for (int j = 0; j < NI; j++)
        s += int'(mem[i]) * j;
    return 24'(s);
  endfunction

  // start pulse, then watch to the done cycle (at phase 0 after the first negedge)
  task automatic run_call(input int poke_at);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    tot = tot + call_sum();
    for (int p = 1; p <= DONE_PH; p++) begin
      if (p == poke_at) start_i = 1'b1;
      @(negedge clk);
      if (p == poke_at) start_i = 1'b0;
    end
    // R6 R5 R8
    chk(done_o == 1'b1, "R6 done at phase 402", done_o, 1);
    chk(result_o == tot, "R5 R8 total after call", result_o, tot);
  endtask

  initial begin
    for (int i = 0; i < NO; i++) mem[i] = 12'(i * 37 - 300);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(rd_en_o == 1'b0, "R1 rd_en", rd_en_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(result_o == '0, "R1 result", result_o, 0);
    chk_on = 1'b1;
    @(negedge clk);

    // ramp data, stray start mid-run (R7)
    run_call(120);
    @(negedge clk);
    // R5: second call adds on top
    for (int i = 0; i < NO; i++) mem[i] = -12'sd2048 + 12'(i);
    run_call(0);
    // R7: start accepted in the done cycle
    for (int i = 0; i < NO; i++) mem[i] = 12'sd2047;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(rd_en_o == 1'b1, "R7 accepted in done cycle", rd_en_o, 1);
    tot = tot + call_sum();
    for (int p = 1; p <= DONE_PH; p++) @(negedge clk);
    chk(done_o == 1'b1, "R7 done of back-to-back call", done_o, 1);
    chk(result_o == tot, "R8 total", result_o, tot);
    // R8: further full-scale calls force wrap
    run_call(0);
    run_call(300);

    // R9: reset in the middle of a call
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (150) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(rd_en_o == 1'b0, "R9 rd_en after reset", rd_en_o, 0);
    chk(result_o == '0, "R9 result after reset", result_o, 0);
    tot = '0;
    begin
      bit seen = 1'b0;
      for (int p = 0; p < 500; p++) begin
        @(negedge clk);
        if (done_o || rd_en_o) seen = 1'b1;
      end
      chk(!seen, "R9 no activity after abort", seen, 0);
    end

    // fresh call after reset, mixed signs
    for (int i = 0; i < NO; i++) mem[i] = (i % 2 == 0) ? 12'(i * 91) : -12'(i * 83);
    run_call(0);

    chk_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule